// File: doc/BRIEF.md
# Cartridge ROM/RAM bank controller

This block sits on the write side of a cartridge port attached to an 8-bit CPU bus. Stores that the CPU aims at the lower 32 KiB (the ROM window) are never passed on to memory. They are decoded as control writes. The block turns them into three registered outputs: a bank number for the switchable upper 16 KiB of ROM, a bank number for the external RAM, and an enable that gates external-RAM access.

A two-bit flavour input picks one of three controller behaviours: no controller, type A or type B. A bank-count input gives the ROM size in 16 KiB banks. Any ROM bank request that would fall outside that size is refused. The ROM and RAM arrays sit outside this block. So do any battery backing and any clock chip.

Top module: `cart_bank_ctrl`

## Requirements
- R1: In type A and type B, a write with address bits [15:13] = 000 sets `ram_en` when the data is 0x0A and clears it when the data is 0x00. Any other data leaves it unchanged. Every output changes at the clock edge that samples the write.
- R2: A write with address bits [15:13] = 001 requests a ROM bank. Type A takes data bits [4:0] and type B takes data bits [6:0]. Higher data bits are ignored.
- R3: In type A, a low field of 0 is turned into 1. The current `rom_bank` bits [6:5] are kept above the new low field.
- R4: In type B, a requested ROM bank of 0 is turned into 1.
- R5: In type B only, a write with address bits [15:13] = 010 and data below 4 loads `ram_bank` with that data. Data of 4 or more is ignored, and type A ignores this range entirely.
- R6: A requested ROM bank that is not below `rom_banks` is refused, and `rom_bank` keeps its previous value.
- R7: While `rst` is high, `rom_bank` = 1, `ram_bank` = 0 and `ram_en` = 0.
- R8: With `mode` = 00 (none) or 11 (reserved), no write changes any output. Type A is encoded as 01 and type B as 10.
- R9: Writes with address bits [15:13] = 011, writes at 0x8000 and above, and cycles with `wr_en` low leave all outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | CPU write strobe, one cycle per store |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| mode | input | 2 | Flavour: 00 none, 01 type A, 10 type B, 11 none |
| rom_banks | input | 8 | ROM size as a count of 16 KiB banks |
| rom_bank | output | 7 | Bank mapped into the upper ROM window |
| ram_bank | output | 2 | Selected external-RAM bank |
| ram_en | output | 1 | External-RAM access enable |

## Verification
ROM-bank writes are driven with a plain in-range value, with data whose bits lie above the flavour's field, and with zero. Together these separate field masking from the zero-to-one remap. Upper-bit preservation is shown by raising bits [6:5] in type B and then writing in type A. The range check is driven with `rom_banks` = 8, using 7 as the last legal bank and 8 and 9 as refused requests. RAM-enable writes use 0x0A, 0x00 and an unrelated value. RAM-bank writes use 2, 3 and 4, and the same range is also written in type A. The ignored 0x6000 range, the upper half of the address space and the two inert flavour codes are each written with data that would change something in another range or flavour.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  typedef enum logic [1:0] {
    FLAV_NONE = 2'b00,
    FLAV_A    = 2'b01,
    FLAV_B    = 2'b10,
    FLAV_RSVD = 2'b11
  } flavour_e;

  typedef struct packed {
    logic gate_wr;
    logic rom_wr;
    logic ram_wr;
  } ctl_strobe_t;

  localparam logic [7:0] GATE_OPEN  = 8'h0A;
  localparam logic [7:0] GATE_CLOSE = 8'h00;

endpackage

// File: rtl/cart_wr_decode.sv
module cart_wr_decode
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        mode,
  output ctl_strobe_t       strobe
);
  localparam int SEL_W = 3;

  logic [SEL_W-1:0] sel;
  logic             flav_on;
  logic             flav_b;
  logic             low_half;

  assign sel      = wr_addr[ADDR_W-1 -: SEL_W];
  assign low_half = ~sel[SEL_W-1];
  assign flav_on  = (mode == FLAV_A) || (mode == FLAV_B);
  assign flav_b   = (mode == FLAV_B);

  always_comb begin
    strobe = '0;
    if (wr_en && flav_on && low_half) begin
      unique case (sel[SEL_W-2:0])
        2'd0: strobe.gate_wr = 1'b1;
        2'd1: strobe.rom_wr  = 1'b1;
        2'd2: strobe.ram_wr  = flav_b;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cart_rom_bank_calc.sv
module cart_rom_bank_calc
  import cart_bank_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int BANK_W  = 7,
  parameter int LOW_A_W = 5,
  parameter int COUNT_W = BANK_W + 1
) (
  input  logic [1:0]         mode,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [BANK_W-1:0]  cur_bank,
  input  logic [COUNT_W-1:0] rom_banks,
  output logic [BANK_W-1:0]  next_bank,
  output logic               legal
);
  localparam int HI_A_W = BANK_W - LOW_A_W;

  logic [LOW_A_W-1:0] low_a;
  logic [BANK_W-1:0]  cand_a;
  logic [BANK_W-1:0]  cand_b;
  logic [COUNT_W-1:0] cand_ext;

  always_comb begin
    low_a = wr_data[LOW_A_W-1:0];
    if (low_a == '0) low_a = LOW_A_W'(1);
    cand_a = {cur_bank[BANK_W-1 -: HI_A_W], low_a};
    cand_b = wr_data[BANK_W-1:0];
    if (cand_b == '0) cand_b = BANK_W'(1);
  end

  assign next_bank = (mode == FLAV_A) ? cand_a : cand_b;
  assign cand_ext  = COUNT_W'(next_bank);
  assign legal     = cand_ext < rom_banks;
endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  ctl_strobe_t           strobe,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [BANK_W-1:0]     next_bank,
  input  logic                  legal,
  output logic [BANK_W-1:0]     rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);
  localparam int RAM_BANKS = 1 << RAM_BANK_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      rom_bank <= BANK_W'(1);
      ram_bank <= '0;
      ram_en   <= 1'b0;
    end else begin
      if (strobe.gate_wr) begin
        if (wr_data == GATE_OPEN)       ram_en <= 1'b1;
        else if (wr_data == GATE_CLOSE) ram_en <= 1'b0;
      end
      if (strobe.rom_wr && legal) rom_bank <= next_bank;
      if (strobe.ram_wr && (int'(wr_data) < RAM_BANKS))
        ram_bank <= wr_data[RAM_BANK_W-1:0];
    end
  end
endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 7,
  parameter int LOW_A_W    = 5,
  parameter int RAM_BANK_W = 2,
  parameter int COUNT_W    = BANK_W + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [1:0]            mode,
  input  logic [COUNT_W-1:0]    rom_banks,
  output logic [BANK_W-1:0]     rom_bank,
  output logic [RAM_BANK_W-1:0] ram_bank,
  output logic                  ram_en
);
  ctl_strobe_t       strobe;
  logic [BANK_W-1:0] next_bank;
  logic              legal;

  cart_wr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .mode    (mode),
    .strobe  (strobe)
  );

  cart_rom_bank_calc #(
    .DATA_W (DATA_W), .BANK_W (BANK_W), .LOW_A_W (LOW_A_W), .COUNT_W (COUNT_W)
  ) calc_i (
    .mode      (mode),
    .wr_data   (wr_data),
    .cur_bank  (rom_bank),
    .rom_banks (rom_banks),
    .next_bank (next_bank),
    .legal     (legal)
  );

  cart_bank_regs #(
    .DATA_W (DATA_W), .BANK_W (BANK_W), .RAM_BANK_W (RAM_BANK_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .wr_data   (wr_data),
    .next_bank (next_bank),
    .legal     (legal),
    .rom_bank  (rom_bank),
    .ram_bank  (ram_bank),
    .ram_en    (ram_en)
  );
endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BANK_W     = 7,
  parameter int RAM_BANK_W = 2,
  parameter int COUNT_W    = BANK_W + 1
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [1:0]            mode,
  input logic [COUNT_W-1:0]    rom_banks,
  input logic [BANK_W-1:0]     rom_bank,
  input logic [RAM_BANK_W-1:0] ram_bank,
  input logic                  ram_en
);
  // R3 R4
  rom_bank_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    rom_bank != '0);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

  // R8
  none_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b00 || mode == 2'b11) |=>
      ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

  // R6
  rom_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rom_bank) |-> ({1'b0, rom_bank} < $past(rom_banks)));

  // R1
  gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ram_en) |-> $past(wr_en && wr_data == 8'h0A &&
                            wr_addr[ADDR_W-1 -: 3] == 3'b000));

  // R5
  ram_bank_src_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(ram_bank) |-> $past(mode == 2'b10 && wr_en &&
                                 wr_addr[ADDR_W-1 -: 3] == 3'b010));
endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W),
  .RAM_BANK_W(RAM_BANK_W), .COUNT_W(COUNT_W)
) chk_i (.*);

// File: tb/cart_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module cart_bank_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  mode = 2'b01;
  logic [7:0]  rom_banks = 8'd128;
  logic [6:0]  rom_bank;
  logic [1:0]  ram_bank;
  logic        ram_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cart_bank_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .rom_banks(rom_banks), .rom_bank(rom_bank),
    .ram_bank(ram_bank), .ram_en(ram_en)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 rom_bank", rom_bank, 1);
    check("R7 ram_bank", ram_bank, 0);
    check("R7 ram_en", ram_en, 0);
  endtask

  task automatic t_gate();
    mode = 2'b01;
    wr(16'h0000, 8'h0A); check("R1 open", ram_en, 1);
    wr(16'h1FFF, 8'h05); check("R1 other value", ram_en, 1);
    wr(16'h1234, 8'h00); check("R1 close", ram_en, 0);
    mode = 2'b10;
    wr(16'h0800, 8'h0A); check("R1 open type B", ram_en, 1);
  endtask

  task automatic t_rom_a();
    mode = 2'b01;
    wr(16'h2000, 8'h13); check("R2 type A plain", rom_bank, 8'h13);
    wr(16'h3FFF, 8'hE7); check("R2 type A mask", rom_bank, 8'h07);
    wr(16'h2000, 8'h00); check("R3 zero remap", rom_bank, 1);
    wr(16'h2000, 8'h20); check("R3 masked zero remap", rom_bank, 1);
  endtask

  task automatic t_rom_b();
    mode = 2'b10;
    wr(16'h2000, 8'h45); check("R2 type B plain", rom_bank, 8'h45);
    wr(16'h2100, 8'hC6); check("R2 type B mask", rom_bank, 8'h46);
    wr(16'h2000, 8'h00); check("R4 zero remap", rom_bank, 1);
    wr(16'h2000, 8'h80); check("R4 masked zero remap", rom_bank, 1);
  endtask

  task automatic t_upper();
    mode = 2'b10; wr(16'h2000, 8'h45);
    mode = 2'b01;
    wr(16'h2000, 8'h03); check("R3 keep upper", rom_bank, 8'h43);
    wr(16'h2000, 8'h00); check("R3 keep upper zero", rom_bank, 8'h41);
    mode = 2'b10; wr(16'h2000, 8'h01);
  endtask

  task automatic t_ram_bank();
    mode = 2'b10;
    wr(16'h4000, 8'h02); check("R5 select 2", ram_bank, 2);
    wr(16'h5FFF, 8'h04); check("R5 ignore 4", ram_bank, 2);
    wr(16'h4000, 8'h03); check("R5 select 3", ram_bank, 3);
    mode = 2'b01;
    wr(16'h4000, 8'h01); check("R5 type A ignores", ram_bank, 3);
  endtask

  task automatic t_range();
    rom_banks = 8'd8; mode = 2'b10;
    wr(16'h2000, 8'h07); check("R6 last legal", rom_bank, 7);
    wr(16'h2000, 8'h08); check("R6 refuse 8", rom_bank, 7);
    mode = 2'b01;
    wr(16'h2000, 8'h09); check("R6 refuse type A", rom_bank, 7);
    wr(16'h2000, 8'h00); check("R6 remapped legal", rom_bank, 1);
    rom_banks = 8'd128;
  endtask

  task automatic t_none();
    mode = 2'b10; wr(16'h0000, 8'h0A); wr(16'h2000, 8'h05); wr(16'h4000, 8'h01);
    mode = 2'b00;
    wr(16'h0000, 8'h00); wr(16'h2000, 8'h09); wr(16'h4000, 8'h02);
    check("R8 none ram_en", ram_en, 1);
    check("R8 none rom", rom_bank, 5);
    check("R8 none ram_bank", ram_bank, 1);
    mode = 2'b11;
    wr(16'h0000, 8'h00); wr(16'h2000, 8'h09);
    check("R8 reserved ram_en", ram_en, 1);
    check("R8 reserved rom", rom_bank, 5);
  endtask

  task automatic t_ignored();
    mode = 2'b10;
    wr(16'h6000, 8'h00); wr(16'h7FFF, 8'h03);
    check("R9 6000 rom", rom_bank, 5);
    check("R9 6000 ram_en", ram_en, 1);
    wr(16'h8000, 8'h00); wr(16'hA000, 8'h09); wr(16'hC000, 8'h02);
    check("R9 high ram_en", ram_en, 1);
    check("R9 high rom", rom_bank, 5);
    check("R9 high ram_bank", ram_bank, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_rom_a();
    t_rom_b();
    t_upper();
    t_ram_bank();
    t_range();
    t_none();
    t_ignored();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    t_reset();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule